// File: doc/BRIEF.md
# Min-Sum Iterative Parity-Check Decoder

This block decodes one frame of a small sparse parity-check code. Each code bit arrives as a signed soft value. A positive value favours a 0 bit, because bit c is sent as the symbol 1-2c. The parity-check matrix is a compile-time parameter. The default code has 7 bits and 3 checks:

- check 0 covers bits 0, 1, 2 and 4;
- check 1 covers bits 0, 2, 3 and 5;
- check 2 covers bits 0, 1, 3 and 6.

Bits 0 to 3 carry the information and bits 4 to 6 carry the parity.

Software-side logic writes the soft values one at a time, by bit index, through a valid/ready port. A transfer happens on a clock edge where both `llr_valid_i` and `llr_ready_o` are high. `llr_ready_o` is high only while the decoder is idle. The writer must therefore hold its data through a busy period, or the write is lost. A one-cycle `start_i` pulse launches decoding. The block keeps one message for every nonzero matrix entry in each direction. It alternates a check update and a variable update for a fixed number of iterations. When early stop is requested, it may instead finish at the first iteration whose decisions satisfy every check. It then raises `done_o` for one cycle. At that point the hard-decided word and the parity flag are valid, and they hold until the next result.

All messages are 6-bit signed values confined to -31..+31. Each check node keeps the smallest and the second-smallest input magnitude, so that no output depends on its own input.

Top module: `ldpc_ms_decoder`

## Requirements
- R1: After reset, `done_o`, `word_o` and `parity_ok_o` are 0 and `llr_ready_o` is 1.
- R2: `llr_ready_o` is high only while idle. A transfer stores the value, clamped to -31..+31, at bit index `llr_idx_i`. A value offered while `llr_ready_o` is low is dropped and does not affect any later frame.
- R3: `start_i` starts a decode only when idle. A start pulse during a decode neither changes that decode's timing nor queues a second one.
- R4: If `start_i` is sampled at edge 1, `done_o` is high for exactly one cycle after edge 2+2k, where k is the number of iterations run. Without early stop, k equals MAX_ITER (default 4).
- R5: A check's message to a bit has the sign of the product of its other inputs' signs, with 0 counted as positive. Its magnitude is the smallest magnitude among those other inputs.
- R6: A bit's message to a check is its soft value plus all incoming check messages except that check's. The posterior is its soft value plus all incoming check messages. Both saturate to -31..+31 and never wrap.
- R7: `word_o` bit i is 1 exactly when the posterior of code bit i is negative; a zero posterior gives 0.
- R8: `parity_ok_o` is 1 exactly when `word_o` satisfies every row of the matrix (even parity over the row's bits).
- R9: With `early_stop_i` high at start, decoding ends after the first iteration whose decisions satisfy all checks. A frame that never satisfies them runs MAX_ITER iterations.
- R10: `word_o` and `parity_ok_o` change only in the cycle where `done_o` is high, and hold otherwise.
- R11: A transfer accepted on the same edge as `start_i` is part of the frame being started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llr_valid_i | input | 1 | Soft-value write offered |
| llr_ready_o | output | 1 | Decoder idle, write accepted |
| llr_idx_i | input | 3 | Bit index of the write |
| llr_data_i | input | 6 | Signed soft value |
| start_i | input | 1 | Start decoding pulse |
| early_stop_i | input | 1 | Allow finishing once all checks pass |
| done_o | output | 1 | One-cycle result pulse |
| word_o | output | 7 | Hard-decided code bits, bit i = code bit i |
| parity_ok_o | output | 1 | All checks satisfied by `word_o` |

## Verification
Two events can coincide at the clock edge where a decode begins: a soft-value write and the start pulse. The bench preloads a frame with one wrong value. It then presents the corrective write and the start pulse in the same cycle. It judges the outcome by whether the clean codeword and a set parity flag come back. A related collision, a write and a second start offered while a decode runs, is provoked mid-frame. It is judged by the unchanged latency, the absence of a second done pulse and the unchanged result of a repeat decode.

// File: rtl/ldpc_ms_pkg.sv
`timescale 1ns/1ps
package ldpc_ms_pkg;
  parameter int MSG_W   = 6;
  parameter int MAG_MAX = (1 << (MSG_W - 1)) - 1;

  typedef logic signed [MSG_W-1:0] msg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_CHK, ST_VAR, ST_DONE
  } dec_st_e;

  // clamp a wide sum to the symmetric message range
  function automatic msg_t sat_msg(input int v);
    if (v > MAG_MAX)  return msg_t'(MAG_MAX);
    if (v < -MAG_MAX) return msg_t'(-MAG_MAX);
    return msg_t'(v);
  endfunction
endpackage

// File: rtl/ldpc_ms_chk.sv
`timescale 1ns/1ps
module ldpc_ms_chk
  import ldpc_ms_pkg::*;
#(
  parameter int N_BITS = 7,
  parameter logic [N_BITS-1:0] ROW = '1
) (
  input  msg_t v_in  [N_BITS],
  output msg_t c_out [N_BITS]
);
  int   min1, min2, min_idx;
  logic par;

  // first and second minimum plus overall sign parity (R5)
  always_comb begin
    min1    = MAG_MAX;
    min2    = MAG_MAX;
    min_idx = 0;
    par     = 1'b0;
    for (int i = 0; i < N_BITS; i++) begin
      if (ROW[i]) begin
        int mag;
        mag = (v_in[i] < 0) ? -int'(v_in[i]) : int'(v_in[i]);
        par = par ^ (v_in[i] < 0);
        if (mag < min1) begin
          min2    = min1;
          min1    = mag;
          min_idx = i;
        end else if (mag < min2) begin
          min2 = mag;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_BITS; i++) begin
      int m;
      m = (i == min_idx) ? min2 : min1;
      if (!ROW[i])                      c_out[i] = '0;
      else if (par ^ (v_in[i] < 0))     c_out[i] = msg_t'(-m);
      else                              c_out[i] = msg_t'(m);
    end
  end
endmodule

// File: rtl/ldpc_ms_var.sv
`timescale 1ns/1ps
module ldpc_ms_var
  import ldpc_ms_pkg::*;
#(
  parameter int N_CHK = 3,
  parameter logic [N_CHK-1:0] COLM = '1
) (
  input  msg_t llr,
  input  msg_t c_in  [N_CHK],
  output msg_t v_out [N_CHK],
  output msg_t post
);
  int total;

  // full sum then exclusion per edge, saturated (R6)
  always_comb begin
    total = int'(llr);
    for (int j = 0; j < N_CHK; j++)
      if (COLM[j]) total = total + int'(c_in[j]);
    post = sat_msg(total);
    for (int j = 0; j < N_CHK; j++)
      v_out[j] = COLM[j] ? sat_msg(total - int'(c_in[j])) : '0;
  end
endmodule

// File: rtl/ldpc_ms_decoder.sv
`timescale 1ns/1ps
module ldpc_ms_decoder
  import ldpc_ms_pkg::*;
#(
  parameter int N_BITS   = 7,
  parameter int N_CHK    = 3,
  parameter logic [N_CHK-1:0][N_BITS-1:0] H = {7'b1001011, 7'b0101101, 7'b0010111},
  parameter int MAX_ITER = 4,
  localparam int IDX_W   = $clog2(N_BITS),
  localparam int IT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    llr_valid_i,
  output logic                    llr_ready_o,
  input  logic [IDX_W-1:0]        llr_idx_i,
  input  logic signed [MSG_W-1:0] llr_data_i,
  input  logic                    start_i,
  input  logic                    early_stop_i,
  output logic                    done_o,
  output logic [N_BITS-1:0]       word_o,
  output logic                    parity_ok_o
);
  function automatic logic [N_CHK-1:0] col_mask(input int c);
    logic [N_CHK-1:0] r;
    for (int j = 0; j < N_CHK; j++) r[j] = H[j][c];
    return r;
  endfunction

  dec_st_e         state_q;
  logic [IT_W-1:0] iter_q;
  logic            early_q;
  msg_t            llr_q   [N_BITS];
  msg_t            v2c_q   [N_CHK][N_BITS];
  msg_t            c2v_q   [N_CHK][N_BITS];
  msg_t            chk_out [N_CHK][N_BITS];
  msg_t            col_c2v [N_BITS][N_CHK];
  msg_t            col_v2c [N_BITS][N_CHK];
  msg_t            post    [N_BITS];
  logic [N_BITS-1:0] hard;
  logic            synd_ok;
  logic            finish;

  assign llr_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  for (genvar j = 0; j < N_CHK; j++) begin : g_chk
    ldpc_ms_chk #(.N_BITS(N_BITS), .ROW(H[j])) chk_i (
      .v_in (v2c_q[j]),
      .c_out(chk_out[j])
    );
  end

  for (genvar i = 0; i < N_BITS; i++) begin : g_var
    for (genvar j = 0; j < N_CHK; j++) begin : g_map
      assign col_c2v[i][j] = c2v_q[j][i];
    end
    ldpc_ms_var #(.N_CHK(N_CHK), .COLM(col_mask(i))) var_i (
      .llr  (llr_q[i]),
      .c_in (col_c2v[i]),
      .v_out(col_v2c[i]),
      .post (post[i])
    );
    assign hard[i] = post[i] < 0;   // R7
  end

  // syndrome of the current decisions (R8)
  always_comb begin
    synd_ok = 1'b1;
    for (int j = 0; j < N_CHK; j++)
      if (^(hard & H[j])) synd_ok = 1'b0;
  end

  assign finish = (int'(iter_q) + 1 >= MAX_ITER) || (early_q && synd_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      iter_q      <= '0;
      early_q     <= 1'b0;
      word_o      <= '0;
      parity_ok_o <= 1'b0;
      for (int i = 0; i < N_BITS; i++) begin
        llr_q[i] <= '0;
        for (int j = 0; j < N_CHK; j++) begin
          v2c_q[j][i] <= '0;
          c2v_q[j][i] <= '0;
        end
      end
    end else begin
      if (llr_valid_i && llr_ready_o && int'(llr_idx_i) < N_BITS)
        llr_q[llr_idx_i] <= sat_msg(int'(llr_data_i));   // R2
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_INIT;
          early_q <= early_stop_i;
          iter_q  <= '0;
        end
        ST_INIT: begin
          for (int j = 0; j < N_CHK; j++)
            for (int i = 0; i < N_BITS; i++)
              v2c_q[j][i] <= H[j][i] ? llr_q[i] : '0;
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          c2v_q   <= chk_out;
          state_q <= ST_VAR;
        end
        ST_VAR: begin
          for (int j = 0; j < N_CHK; j++)
            for (int i = 0; i < N_BITS; i++)
              v2c_q[j][i] <= col_v2c[i][j];
          iter_q <= iter_q + 1'b1;
          if (finish) begin
            word_o      <= hard;
            parity_ok_o <= synd_ok;
            state_q     <= ST_DONE;
          end else begin
            state_q <= ST_CHK;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_iter_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(iter_q) <= MAX_ITER);
  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(word_o) || !$stable(parity_ok_o)) |-> done_o);
  p_early_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && early_q && int'(iter_q) < MAX_ITER) |-> parity_ok_o);
  p_no_busy_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !llr_ready_o |=> $stable(llr_q[0]));
endmodule

// File: tb/ldpc_ms_decoder_tb.sv
`timescale 1ns/1ps
module ldpc_ms_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic llr_valid = 1'b0;
  logic llr_ready;
  logic [2:0] llr_idx = '0;
  logic signed [5:0] llr_data = '0;
  logic start = 1'b0;
  logic early = 1'b0;
  logic done;
  logic [6:0] word;
  logic parity_ok;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldpc_ms_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .llr_valid_i(llr_valid), .llr_ready_o(llr_ready),
    .llr_idx_i(llr_idx), .llr_data_i(llr_data),
    .start_i(start), .early_stop_i(early),
    .done_o(done), .word_o(word), .parity_ok_o(parity_ok)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int v0, v1, v2, v3, v4, v5, v6);
    int vals [7];
    vals = '{v0, v1, v2, v3, v4, v5, v6};
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      llr_valid = 1'b1;
      llr_idx   = 3'(i);
      llr_data  = 6'(vals[i]);
      @(posedge clk);
    end
    @(negedge clk);
    llr_valid = 1'b0;
  endtask

  // start a frame; optional write on the start edge (R11) and mid-run pokes (R2, R3)
  task automatic run_frame(input string req, input bit early_en, input int exp_word,
                           input int exp_ok, input int exp_iter, input bit poke,
                           input bit wr_same, input int wr_val);
    int n;
    logic [6:0] w_hold;
    @(negedge clk);
    start = 1'b1;
    early = early_en;
    if (wr_same) begin
      llr_valid = 1'b1; llr_idx = 3'd0; llr_data = 6'(wr_val);
    end
    n = 0;
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      llr_valid = 1'b0;
      if (poke && n == 1) begin
        llr_valid = 1'b1; llr_idx = 3'd0; llr_data = 6'sd31;
      end
      if (poke && n == 2) check("R2", "ready while busy", int'(llr_ready), 0);
      if (poke && n == 3) start = 1'b1;
      if (done) break;
    end
    check("R4", {req, " done latency"}, n, 2 + 2 * exp_iter);
    check("R7", {req, " word"}, int'(word), exp_word);
    check("R8", {req, " parity_ok"}, int'(parity_ok), exp_ok);
    w_hold = word;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", {req, " done dropped / no requeue"}, int'(done), 0);
    end
    check("R10", {req, " word held"}, int'(word), int'(w_hold));
  endtask

  task automatic t_reset();
    check("R1", "done after reset", int'(done), 0);
    check("R1", "word after reset", int'(word), 0);
    check("R1", "parity_ok after reset", int'(parity_ok), 0);
    check("R1", "ready after reset", int'(llr_ready), 1);
  endtask

  task automatic t_all_zero();
    load(10, 10, 10, 10, 10, 10, 10);
    run_frame("R9 zero early", 1'b1, 0, 1, 1, 1'b0, 1'b0, 0);
    run_frame("R4 zero full", 1'b0, 0, 1, MAXI, 1'b0, 1'b0, 0);
  endtask

  task automatic t_single_error();
    // weak wrong bit 0 corrected by three positive check messages (R5, R6)
    load(-3, 10, 10, 10, 10, 10, 10);
    run_frame("R5 correct bit0", 1'b1, 0, 1, 1, 1'b0, 1'b0, 0);
    run_frame("R5 correct bit0 full", 1'b0, 0, 1, MAXI, 1'b0, 1'b0, 0);
  endtask

  task automatic t_codeword();
    // codeword 1000111: bits 0,4,5,6 set
    load(-10, 10, 10, 10, -10, -10, -10);
    run_frame("R7 codeword", 1'b1, 7'b1110001, 1, 1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_busy();
    // write and start during a decode are dropped (R2, R3)
    run_frame("R3 busy pokes", 1'b0, 7'b1110001, 1, MAXI, 1'b1, 1'b0, 0);
    run_frame("R2 after dropped write", 1'b1, 7'b1110001, 1, 1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_saturate();
    // all-ones codeword at the negative limit; -32 clamps, sums must not wrap (R6)
    load(-32, -32, -32, -32, -32, -32, -32);
    run_frame("R6 saturation", 1'b0, 7'h7F, 1, MAXI, 1'b0, 1'b0, 0);
  endtask

  task automatic t_unsat();
    // zero-magnitude checks stay at zero; bit4 stays set and check 0 fails (R9, R8)
    load(0, 0, 0, 0, -8, 0, 0);
    run_frame("R9 no early exit", 1'b1, 7'b0010000, 0, MAXI, 1'b0, 1'b0, 0);
  endtask

  task automatic t_same_cycle();
    // bit 0 preloaded wrong, corrected on the start edge (R11)
    load(10, 10, 10, 10, -10, -10, -10);
    run_frame("R11 same-edge write", 1'b1, 7'b1110001, 1, 1, 1'b0, 1'b1, -10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_zero();
    t_single_error();
    t_codeword();
    t_busy();
    t_saturate();
    t_unsat();
    t_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule